// File: doc/BRIEF.md
# Asymmetric Lock Qualification Detector

This block turns per-cycle phase error samples from a phase-locked loop into a single lock flag. Between two cycle strobes it counts the sampling-clock ticks during which the phase detector's up or down pulse is active. That count is the phase error of the comparison cycle. At each strobe the count is compared with a programmable threshold, and the cycle is classed as good or bad.

Qualification is deliberately lopsided. The flag rises only after eight good cycles in a row, and it falls on the first bad cycle. A programmable timeout turns a missing strobe into a bad cycle, so a stopped reference also drops lock. A hold input, meant to be tied to the loop's clear input, keeps the flag low and the qualification count at zero while it is asserted.

Top module: `lock_qual_detector`

## Requirements
- R1: After reset, `lockOut` is 0 and qualification starts from zero good cycles.
- R2: The error of a cycle is the number of clock edges at which `upPulse` or `dnPulse` (either or both, counted once) was high after the previous strobe cycle. The level on the strobe cycle itself belongs to the next window.
- R3: The error count saturates at 65535 and does not wrap.
- R4: A strobe cycle is good when error <= `errThresh`, so an error equal to the threshold counts as good. It is bad when error > `errThresh`.
- R5: `lockOut` rises in the clock after the eighth consecutive good strobe, and not earlier.
- R6: A single bad cycle clears `lockOut` in the next clock and restarts qualification from zero, so eight new good cycles are needed.
- R7: While `holdIn` is high, `lockOut` is 0 from the next clock on and the qualification count is zero. After release, eight new good cycles are needed.
- R8: With `timeoutLimit` = L > 0, L consecutive clocks without a strobe count as one bad cycle. L = 0 disables the timeout.
- R9: Good cycles beyond the eighth keep `lockOut` high; the qualification count saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upPulse | input | 1 | Phase detector up pulse |
| dnPulse | input | 1 | Phase detector down pulse |
| cycStrobe | input | 1 | One-clock marker of the end of a comparison cycle |
| errThresh | input | 16 | Largest error, in ticks, that still counts as good |
| timeoutLimit | input | 20 | Clocks without a strobe that count as a bad cycle (0 = off) |
| holdIn | input | 1 | Clears qualification and lock while high |
| lockOut | output | 1 | Lock flag |

## Verification
A qualification count that is off by one shows up as `lockOut` rising one strobe too early or too late in an eight-cycle run. A count that is not cleared shows up as lock returning in fewer than eight strobes after a bad cycle or a hold. A faulty error counter, such as one that wraps, double-counts overlapping up and down pulses, or assigns the strobe-cycle sample to the wrong window, flips the good/bad decision at the threshold boundary. That changes the flag one clock after the affected strobe. A faulty idle counter shows up as lock dropping too soon or not at all after strobes stop.

// File: rtl/lqd_pkg.sv
package lqd_pkg;
  typedef struct packed {
    logic cycGood;
    logic cycBad;
  } lqd_evt_t;
endpackage

// File: rtl/lqd_datapath.sv
module lqd_datapath
  import lqd_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upPulse,
  input  logic             dnPulse,
  input  logic             cycStrobe,
  input  logic [ERR_W-1:0] errThresh,
  input  logic [TMO_W-1:0] timeoutLimit,
  output lqd_evt_t         evt
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [ERR_W-1:0] errCnt;
  logic [TMO_W-1:0] idleCnt;
  logic             pulseActive;
  logic             timeoutHit;
  logic             overThresh;

  assign pulseActive = upPulse | dnPulse;
  assign overThresh  = errCnt > errThresh;
  assign timeoutHit  = !cycStrobe && (timeoutLimit != '0) &&
                       (idleCnt == timeoutLimit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errCnt <= '0;
    end else if (cycStrobe) begin
      errCnt <= pulseActive ? ERR_W'(1) : '0;
    end else if (pulseActive && errCnt != ERR_MAX) begin
      errCnt <= errCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (cycStrobe || timeoutHit) begin
      idleCnt <= '0;
    end else if (timeoutLimit != '0) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    evt.cycGood = cycStrobe && !overThresh;
    evt.cycBad  = (cycStrobe && overThresh) || timeoutHit;
  end
endmodule

// File: rtl/lqd_control.sv
module lqd_control
  import lqd_pkg::*;
#(
  parameter int QUAL_LEN = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     holdIn,
  input  lqd_evt_t evt,
  output logic     lockOut
);
  localparam int CNT_W = $clog2(QUAL_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUAL_LEN);

  logic [CNT_W-1:0] qualCnt;
  logic [CNT_W-1:0] qualNext;

  assign qualNext = (qualCnt == CNT_TOP) ? qualCnt : qualCnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qualCnt <= '0;
      lockOut <= 1'b0;
    end else if (holdIn || evt.cycBad) begin
      qualCnt <= '0;
      lockOut <= 1'b0;
    end else if (evt.cycGood) begin
      qualCnt <= qualNext;
      lockOut <= (qualNext == CNT_TOP);
    end
  end
endmodule

// File: rtl/lock_qual_detector.sv
module lock_qual_detector
  import lqd_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int TMO_W    = 20,
  parameter int QUAL_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upPulse,
  input  logic             dnPulse,
  input  logic             cycStrobe,
  input  logic [ERR_W-1:0] errThresh,
  input  logic [TMO_W-1:0] timeoutLimit,
  input  logic             holdIn,
  output logic             lockOut
);
  lqd_evt_t evt;

  lqd_datapath #(.ERR_W(ERR_W), .TMO_W(TMO_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .upPulse(upPulse), .dnPulse(dnPulse),
    .cycStrobe(cycStrobe), .errThresh(errThresh),
    .timeoutLimit(timeoutLimit), .evt(evt)
  );

  lqd_control #(.QUAL_LEN(QUAL_LEN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .holdIn(holdIn), .evt(evt), .lockOut(lockOut)
  );
endmodule

// File: rtl/lqd_checker.sv
module lqd_checker
  import lqd_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     cycStrobe,
  input logic     holdIn,
  input lqd_evt_t evt,
  input logic     lockOut
);
  AST_HOLD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    holdIn |=> !lockOut); // R7
  AST_BAD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cycBad |=> !lockOut); // R6
  AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockOut) |-> $past(evt.cycGood)); // R5
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({evt.cycGood, evt.cycBad}) <= 1); // R4
  AST_STROBE_CLASSIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    cycStrobe |-> (evt.cycGood || evt.cycBad)); // R4
  AST_LOCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.cycGood && !evt.cycBad && !holdIn) |=> $stable(lockOut)); // R9
endmodule

bind lock_qual_detector lqd_checker u_lqd_checker (
  .clk(clk), .rst_n(rst_n), .cycStrobe(cycStrobe), .holdIn(holdIn),
  .evt(evt), .lockOut(lockOut)
);

// File: tb/lock_qual_detector_bench.sv
`timescale 1ns/1ps
module lock_qual_detector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upPulse = 1'b0;
  logic        dnPulse = 1'b0;
  logic        cycStrobe = 1'b0;
  logic [15:0] errThresh = '0;
  logic [19:0] timeoutLimit = '0;
  logic        holdIn = 1'b0;
  logic        lockOut;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  lock_qual_detector u_lock_qual_detector (
    .clk(clk), .rst_n(rst_n), .upPulse(upPulse), .dnPulse(dnPulse),
    .cycStrobe(cycStrobe), .errThresh(errThresh),
    .timeoutLimit(timeoutLimit), .holdIn(holdIn), .lockOut(lockOut)
  );

  localparam int NV = 14;
  localparam int VW [NV] = '{3, 10, 0, 7, 2, 9, 1, 10, 4, 11, 20, 5, 6, 5};
  localparam int VT [NV] = '{10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 30, 5, 5, 5};
  localparam bit VE [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0};

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lockOut=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; upPulse = 0; dnPulse = 0; cycStrobe = 0; holdIn = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // pulse for w clocks, then strobe; returns at the negedge after the strobe edge
  task automatic cycle(input int w, input int thr, input bit up, input bit dn);
    errThresh = 16'(thr);
    if (w > 0) begin
      upPulse = up; dnPulse = dn;
      repeat (w) @(negedge clk);
      upPulse = 0; dnPulse = 0;
    end
    cycStrobe = 1'b1;
    @(negedge clk);
    cycStrobe = 1'b0;
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) cycle(1, 5, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    timeoutLimit = '0;
    repeat (2) @(negedge clk);
    check(lockOut, 1'b0, "R1 in reset");
    doReset();
    check(lockOut, 1'b0, "R1 after reset");

    // table walk: R2 widths, R4 equality, R5 eighth good, R9 extra good, R6 bad
    for (int i = 0; i < NV; i++) begin
      cycle(VW[i], VT[i], 1'b1, 1'b0);
      check(lockOut, VE[i], $sformatf("R4/R5/R6/R9 vector %0d", i));
    end

    // R5: seven goods not enough, eighth locks
    doReset();
    goods(7);
    check(lockOut, 1'b0, "R5 after seven goods");
    goods(1);
    check(lockOut, 1'b1, "R5 after eight goods");
    goods(3);
    check(lockOut, 1'b1, "R9 stays locked");

    // R2: overlapping up and down counted once; strobe-cycle sample goes to next window
    cycle(4, 4, 1'b1, 1'b1);
    check(lockOut, 1'b1, "R2 overlap counted once");
    errThresh = 16'd3;
    upPulse = 1'b1; cycStrobe = 1'b1;
    @(negedge clk);
    cycStrobe = 1'b0;
    repeat (2) @(negedge clk);
    upPulse = 1'b0;
    cycStrobe = 1'b1;
    @(negedge clk);
    cycStrobe = 1'b0;
    check(lockOut, 1'b1, "R2 strobe-cycle sample in new window (3<=3)");
    cycle(6, 5, 1'b0, 1'b1);
    check(lockOut, 1'b0, "R2 down pulse error 6 over 5");

    // R6: after a bad cycle, seven goods are not enough
    goods(7);
    check(lockOut, 1'b0, "R6 requalify needs eight");
    goods(1);
    check(lockOut, 1'b1, "R6 requalified");

    // R7: hold
    holdIn = 1'b1;
    @(negedge clk);
    check(lockOut, 1'b0, "R7 hold clears lock");
    goods(2);
    check(lockOut, 1'b0, "R7 goods ignored during hold");
    holdIn = 1'b0;
    goods(7);
    check(lockOut, 1'b0, "R7 after release seven goods");
    goods(1);
    check(lockOut, 1'b1, "R7 after release eight goods");

    // R8: timeout
    timeoutLimit = 20'd20;
    repeat (10) @(negedge clk);
    check(lockOut, 1'b1, "R8 before timeout");
    repeat (15) @(negedge clk);
    check(lockOut, 1'b0, "R8 timeout drops lock");
    timeoutLimit = 20'd0;
    doReset();
    goods(8);
    repeat (100) @(negedge clk);
    check(lockOut, 1'b1, "R8 zero limit disables timeout");

    // R3: saturation
    doReset();
    goods(7);
    cycle(66000, 65535, 1'b1, 1'b0);
    check(lockOut, 1'b1, "R3 saturated error equals 65535 threshold");
    cycle(66000, 65534, 1'b1, 1'b0);
    check(lockOut, 1'b0, "R3 saturated error above 65534");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule